// File: doc/BRIEF.md
# Thermal Override Clock Throttle Controller

This block guards a processor against a sustained thermal alarm that arrives while the clock-control logic has parked the processor in its stop-grant state. The active-low alarm input is first synchronised. If it then stays asserted for longer than a programmable sustain interval while the current clock state is stop-grant, the block takes over the active-low stop-clock output and throttles the processor with a fixed duty pattern.

While throttling, the clock-state input is ignored. When the synchronised alarm clears, override ends. For one cycle, stop-clock is driven to the level of the clock state saved at entry, and after that it follows the clock-state input again. A single enable bit in a small global enable register, reached through a simple write/read port, selects whether the return from override also raises a one-cycle break pulse. With the bit clear, alarm deassertion is the only way out of override.

Top module: `therm_throttle_ctrl`

## Requirements
- R1: While reset is held, brk_pulse is 0, cfg_rdata reads 8'h00 at offset 8'h20, and stop_clk_n follows the clock state.
- R2: Override begins on the rising clock edge at which the synchronised alarm has already been seen asserted, in stop-grant (clk_state 2'b01), on more than SUSTAIN_CYCLES consecutive edges. Counting from the first edge that samples alarm_n low, this is edge SUSTAIN_CYCLES+3. A hold of exactly SUSTAIN_CYCLES sampled cycles does not start override.
- R3: The sustain count restarts from zero whenever the synchronised alarm is deasserted or clk_state is not stop-grant.
- R4: During override, stop_clk_n is 0 for DUTY cycles out of every PERIOD cycles. The first cycle of override is in the asserted (0) phase.
- R5: During override, changes on clk_state have no effect on stop_clk_n.
- R6: Override ends on the edge at which the synchronised alarm is seen deasserted. In the following cycle, stop_clk_n equals the level of the state saved at entry (0 for stop-grant). After that, it follows clk_state.
- R7: With the break-enable bit at 1, brk_pulse is high for exactly the one cycle after override ends. With the bit at 0, no pulse is produced.
- R8: The global enable register sits at offset 8'h20 and resets to 8'h00. The break-enable bit is read/write at bit 3. Every other bit reads 0, and other offsets read 8'h00 and ignore writes.
- R9: Outside override, stop_clk_n is 1 for clk_state 2'b00 (running) and 0 for the other three codes. Only 2'b01 can lead to override.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_n | input | 1 | Asynchronous active-low thermal alarm |
| clk_state | input | 2 | Current clock-control state: 00 running, 01 stop-grant, 10/11 other low-power states |
| stop_clk_n | output | 1 | Active-low stop-clock to the processor |
| brk_pulse | output | 1 | One-cycle break event on return from override |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |

## Verification
The hardest situation to reach from the ports is an alarm hold that sits exactly on the sustain boundary. It interacts with the two synchroniser cycles and with a state change or a one-cycle alarm gap that must restart the count. The stimulus drives hold lengths of exactly SUSTAIN_CYCLES and SUSTAIN_CYCLES+1 against a small sustain parameter. It also drives runs broken by a single deasserted cycle and by a single excursion out of stop-grant. A cycle-accurate scoreboard predicts every stop-clock and break value from the requirements, so an off-by-one in qualification, in the throttle phase or in the restore cycle shows up as a mismatch.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
  typedef enum logic [1:0] {
    CS_RUN        = 2'b00,
    CS_STOP_GRANT = 2'b01,
    CS_LOWPWR_A   = 2'b10,
    CS_LOWPWR_B   = 2'b11
  } clk_state_e;

  localparam logic [7:0] GEN_ENA_OFFSET = 8'h20;

  // Level of stop_clk_n for a clock state outside override: high only when running.
  function automatic logic idle_stop_level(input logic [1:0] st);
    return (st == CS_RUN);
  endfunction

  // Throttle phase: stop asserted while the phase index is below the duty count.
  function automatic logic throttle_asserted(input logic [31:0] ph, input logic [31:0] duty);
    return (ph < duty);
  endfunction

  // Modulo increment of the phase index.
  function automatic logic [31:0] phase_next(input logic [31:0] ph, input logic [31:0] period);
    return (ph + 32'd1 >= period) ? 32'd0 : ph + 32'd1;
  endfunction
endpackage

// File: rtl/thr_sync.sv
`timescale 1ns/1ps
module thr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = sh_q[STAGES-1];
endmodule

// File: rtl/thr_sustain.sv
`timescale 1ns/1ps
module thr_sustain #(
  parameter int unsigned LIMIT = 66_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qualify,
  input  logic hold_clear,
  output logic at_limit
);
  localparam int unsigned CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!qualify || hold_clear) cnt_q <= '0;
    else if (cnt_q != LIM_V)         cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LIM_V);
endmodule

// File: rtl/thr_phase.sv
`timescale 1ns/1ps
module thr_phase
  import thr_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned DUTY   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic stop_now
);
  localparam int unsigned PH_W = (PERIOD < 2) ? 1 : $clog2(PERIOD);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (start) ph_q <= '0;
    else if (run)   ph_q <= PH_W'(phase_next(32'(ph_q), 32'(PERIOD)));
  end

  assign stop_now = throttle_asserted(32'(ph_q), 32'(DUTY));
endmodule

// File: rtl/thr_genreg.sv
`timescale 1ns/1ps
module thr_genreg #(
  parameter int unsigned   ADDR_W = 8,
  parameter int unsigned   DATA_W = 8,
  parameter logic [7:0]    OFFSET = 8'h20,
  parameter int unsigned   EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              brk_en
);
  logic hit;
  logic en_q;

  assign hit = (addr == ADDR_W'(OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= 1'b0;
    else if (we && hit) en_q <= wdata[EN_BIT];
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata[EN_BIT] = en_q;
  end

  assign brk_en = en_q;
endmodule

// File: rtl/therm_throttle_ctrl.sv
`timescale 1ns/1ps
module therm_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int unsigned SUSTAIN_CYCLES = 66_000_000,
  parameter int unsigned PERIOD         = 8,
  parameter int unsigned DUTY           = 4,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned EN_BIT         = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alarm_n,
  input  logic [1:0] clk_state,
  output logic       stop_clk_n,
  output logic       brk_pulse,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata
);
  // Named internal events, visible to the bound checker.
  logic       alarm_sync;
  logic       in_sg;
  logic       at_limit;
  logic       enter_evt;
  logic       exit_evt;
  logic       ovr_active;
  logic       restore_q;
  logic [1:0] saved_q;
  logic       brk_q;
  logic       brk_en;
  logic       thr_stop;

  thr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(~alarm_n), .q_sync(alarm_sync)
  );

  assign in_sg = (clk_state == CS_STOP_GRANT);

  thr_sustain #(.LIMIT(SUSTAIN_CYCLES)) u_sus (
    .clk(clk), .rst_n(rst_n),
    .qualify(alarm_sync && in_sg), .hold_clear(ovr_active),
    .at_limit(at_limit)
  );

  assign enter_evt = !ovr_active && alarm_sync && in_sg && at_limit;
  assign exit_evt  = ovr_active && !alarm_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_active <= 1'b0;
      restore_q  <= 1'b0;
      saved_q    <= CS_RUN;
      brk_q      <= 1'b0;
    end else begin
      if (enter_evt)     ovr_active <= 1'b1;
      else if (exit_evt) ovr_active <= 1'b0;
      if (enter_evt) saved_q <= clk_state;
      restore_q <= exit_evt;
      brk_q     <= exit_evt && brk_en;
    end
  end

  thr_phase #(.PERIOD(PERIOD), .DUTY(DUTY)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(enter_evt), .run(ovr_active),
    .stop_now(thr_stop)
  );

  thr_genreg #(.ADDR_W(8), .DATA_W(8), .OFFSET(GEN_ENA_OFFSET), .EN_BIT(EN_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .brk_en(brk_en)
  );

  always_comb begin
    if (ovr_active)     stop_clk_n = !thr_stop;
    else if (restore_q) stop_clk_n = idle_stop_level(saved_q);
    else                stop_clk_n = idle_stop_level(clk_state);
  end

  assign brk_pulse = brk_q;
endmodule

// File: rtl/therm_throttle_chk.sv
`timescale 1ns/1ps
module therm_throttle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alarm_sync,
  input logic [1:0] clk_state,
  input logic       ovr_active,
  input logic       stop_clk_n,
  input logic       brk_pulse,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_rdata
);
  assert_enter_in_sg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_active) |-> ($past(clk_state) == 2'b01) && $past(alarm_sync));

  assert_start_asserted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_active) |-> !stop_clk_n);

  assert_hold_needs_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_active |-> $past(alarm_sync));

  assert_restore_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_active) |-> !stop_clk_n);

  assert_brk_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);

  assert_brk_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> !ovr_active && $past(ovr_active));

  assert_other_offset_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != 8'h20) |-> (cfg_rdata == 8'h00));

  assert_unused_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'hF7) == 8'h00);
endmodule

bind therm_throttle_ctrl therm_throttle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_sync(alarm_sync), .clk_state(clk_state),
  .ovr_active(ovr_active), .stop_clk_n(stop_clk_n), .brk_pulse(brk_pulse),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/tb_therm_throttle_ctrl.sv
`timescale 1ns/1ps
module tb_therm_throttle_ctrl;
  localparam int unsigned SUST   = 6;
  localparam int unsigned PERIOD = 5;
  localparam int unsigned DUTY   = 2;
  localparam int unsigned EN_BIT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_n = 1'b1;
  logic [1:0] clk_state = 2'b00;
  logic       stop_clk_n;
  logic       brk_pulse;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h20;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;

  therm_throttle_ctrl #(.SUSTAIN_CYCLES(SUST), .PERIOD(PERIOD), .DUTY(DUTY),
                        .SYNC_STAGES(2), .EN_BIT(EN_BIT)) dut (
    .clk(clk), .rst_n(rst_n), .alarm_n(alarm_n), .clk_state(clk_state),
    .stop_clk_n(stop_clk_n), .brk_pulse(brk_pulse), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic  stop;
    logic  brk;
    string req;
  } exp_t;

  exp_t sb[$];
  int   errs = 0;
  int   checks = 0;
  bit   done = 1'b0;
  string cur_req = "R9";

  // Requirement-level predictor state.
  int unsigned p_run = 0;
  int unsigned p_ph = 0;
  bit p_ovr = 0, p_d1 = 0, p_d2 = 0, p_en = 0;
  bit cur_low = 0;
  logic [1:0] cur_st = 2'b00;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the predicted outputs.
  task automatic step(input bit alarm_low, input logic [1:0] st,
                      input bit we = 0, input logic [7:0] addr = 8'h20, input logic [7:0] wd = 8'h00);
    bit exiting;
    exp_t e;
    @(negedge clk);
    alarm_n = ~alarm_low; clk_state = st;
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    cur_low = alarm_low; cur_st = st;
    exiting = 0;
    if (p_ovr) begin
      if (!p_d2) begin p_ovr = 0; exiting = 1; p_run = 0; end
      else p_ph = (p_ph + 1) % PERIOD;
    end else if (p_d2 && st == 2'b01) begin
      if (p_run == SUST) begin p_ovr = 1; p_ph = 0; p_run = 0; end
      else p_run++;
    end else begin
      p_run = 0;
    end
    e.stop = p_ovr ? (p_ph >= DUTY) : (exiting ? 1'b0 : (st == 2'b00));
    e.brk  = exiting && p_en;
    e.req  = cur_req;
    sb.push_back(e);
    if (we && addr == 8'h20) p_en = wd[EN_BIT];
    p_d2 = p_d1; p_d1 = alarm_low;
  endtask

  task automatic cfg_write(input logic [7:0] addr, input logic [7:0] wd);
    step(cur_low, cur_st, 1'b1, addr, wd);
  endtask

  task automatic cfg_read(input logic [7:0] addr, input logic [7:0] exp);
    step(cur_low, cur_st, 1'b0, addr, 8'h00);
    @(posedge clk); #1;
    chk(cfg_rdata, exp, "R8", "cfg_rdata");
  endtask

  task automatic repeat_step(input int n, input bit alarm_low, input logic [1:0] st);
    for (int i = 0; i < n; i++) step(alarm_low, st);
  endtask

  // Monitor: compares outputs with the scoreboard just after each edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({7'd0, stop_clk_n}, {7'd0, e.stop}, e.req, "stop_clk_n");
        chk({7'd0, brk_pulse},  {7'd0, e.brk},  (e.brk || brk_pulse) ? "R7" : e.req, "brk_pulse");
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk({7'd0, stop_clk_n}, 8'd1, "R1", "stop_clk_n in reset, running");
    chk({7'd0, brk_pulse},  8'd0, "R1", "brk_pulse in reset");
    chk(cfg_rdata, 8'h00, "R1", "register in reset");
    clk_state = 2'b01; #1;
    chk({7'd0, stop_clk_n}, 8'd0, "R1", "stop_clk_n in reset, stop-grant");
    clk_state = 2'b00;
    @(negedge clk); rst_n = 1'b1;

    // R9: levels outside override, no override outside stop-grant
    cur_req = "R9";
    repeat_step(3, 0, 2'b00);
    repeat_step(12, 1, 2'b00);
    repeat_step(12, 1, 2'b10);
    repeat_step(4, 0, 2'b01);

    // R8: register decode and bit placement
    cfg_write(8'h21, 8'hFF);
    cfg_read(8'h21, 8'h00);
    cfg_read(8'h20, 8'h00);
    cfg_write(8'h20, 8'hF7);
    cfg_read(8'h20, 8'h00);
    cfg_write(8'h20, 8'hFF);
    cfg_read(8'h20, 8'h08);

    // R2: boundary holds
    cur_req = "R2";
    repeat_step(SUST, 1, 2'b01);
    repeat_step(6, 0, 2'b01);
    repeat_step(SUST + 1, 1, 2'b01);
    repeat_step(6, 0, 2'b01);

    // R3: count restart on a one-cycle gap and on a state excursion
    cur_req = "R3";
    repeat_step(4, 1, 2'b01);
    repeat_step(1, 0, 2'b01);
    repeat_step(5, 1, 2'b01);
    repeat_step(5, 0, 2'b01);
    repeat_step(4, 1, 2'b01);
    repeat_step(1, 1, 2'b00);
    repeat_step(4, 1, 2'b01);
    repeat_step(5, 0, 2'b01);

    // R4, R5, R6, R7: long episode, state change during override, exit with break
    cur_req = "R4";
    repeat_step(14, 1, 2'b01);
    cur_req = "R5";
    repeat_step(8, 1, 2'b00);
    cur_req = "R6";
    repeat_step(6, 0, 2'b00);

    // R7: break disabled
    cfg_write(8'h20, 8'h00);
    cfg_read(8'h20, 8'h00);
    cur_req = "R7";
    repeat_step(12, 1, 2'b01);
    repeat_step(6, 0, 2'b01);

    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule